// File: doc/BRIEF.md
# Three-Term NCO Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. On every clock it forms a 48-bit phase increment from three frequency terms: a center word, an offset word and a short serial tuning word. It then adds that increment to a free-running 48-bit phase accumulator. Each term has its own enable, and a disabled term counts as zero. The serial word is placed so that its most significant bit lands on bit 47 of the increment. The top 24 bits of the accumulated phase leave the block as a lookup address for a sine table that sits downstream.

A two-bit quadrant select rotates the output by 0°, 90°, 180° or 270°. It does this by adding into the two top address bits after accumulation, so it supports simple phase keying and sine/cosine pairs. The offset enable gives fast two-tone frequency keying. The offset enable and the quadrant select may come from outside the clock domain, so each passes through a two-flop synchronizer. A valid flag follows the data through the pipeline.

Top module: `nco_phase_core`

## Requirements
- R1: The phase increment is the sum of the enabled terms modulo 2^48, and any carry out of bit 47 is lost. For example, a center word of 0x4000_0000_0000 plus an offset word of 0xC000_0000_0000 gives an increment of zero.
- R2: Each term is forced to zero on its own when its enable is low: `center_en` for the center word, `serial_en` for the serial word and the synchronized `offset_en` for the offset word.
- R3: The 48-bit accumulator advances by the current increment on every clock and wraps past full scale to zero. `phase_addr` carries accumulator bits 47:24, before the quadrant rotation is added.
- R4: `serial_len` code n (0 to 4) selects a serial word of 8·(n+1) bits, taken from the low bits of `serial_word`. That word is placed with its MSB at bit 47, and all lower increment bits are zero. Unused upper input bits are ignored. Codes 5 to 7 act as 40 bits.
- R5: `quad_sel` value q adds q to address bits 23:22 modulo 4. Address bits 21:0 are not affected.
- R6: While `rst` is high at a clock edge, the accumulator clears to zero, the increment register loads 0x4000_0000_0000, and `phase_addr` and `addr_valid` go to zero. With all terms disabled after release, the address reads 0 after the first edge and 0x400000 after the second and later edges.
- R7: The words, `center_en` and `serial_en` are registered into the increment one edge after they are presented. `quad_sel` reaches the address three edges after a change. A change of `offset_en` first changes the address step at the fifth edge.
- R8: `addr_valid` is `in_valid` delayed by exactly three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the presented frequency terms as valid |
| center_word | input | 48 | Center frequency term |
| center_en | input | 1 | Enables the center term |
| offset_word | input | 48 | Offset frequency term |
| offset_en | input | 1 | Enables the offset term, may be asynchronous |
| serial_word | input | 40 | Serial tuning word, right-justified |
| serial_len | input | 3 | Serial word length code |
| serial_en | input | 1 | Enables the serial term |
| quad_sel | input | 2 | Quadrant phase rotation, may be asynchronous |
| phase_addr | output | 24 | Sine lookup address |
| addr_valid | output | 1 | Address carries a valid sample |

## Verification
The assertions assume that `rst` is high from time zero until at least one clock edge has passed, so that every pipeline register holds a defined value before any property is checked. They also assume that `offset_en` and `quad_sel` only change away from the active edge, because the synchronizer check compares sampled values. The bench drives every input at the falling edge and holds reset for several cycles at start-up. All frequency words in the bench have their low 24 bits at zero, so the step between two addresses equals the expected increment exactly and no carry comes up from the hidden phase bits.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int PHASE_W   = 48;
  localparam int ADDR_W    = 24;
  localparam int SER_W     = 40;
  localparam int SER_BYTES = SER_W / 8;
  localparam int LEN_W     = 3;
  localparam int QUAD_W    = 2;
  localparam int PAD_W     = PHASE_W - SER_W;

  localparam logic [PHASE_W-1:0] RESET_CENTER = 48'h4000_0000_0000;

  // number of serial bytes selected by a length code, out-of-range codes saturate
  function automatic int serial_bytes(input logic [LEN_W-1:0] len);
    int n;
    if (int'(len) >= SER_BYTES - 1) n = SER_BYTES;
    else                            n = int'(len) + 1;
    return n;
  endfunction

  // left-justify the selected low bytes of the serial word at the phase MSB
  function automatic logic [PHASE_W-1:0] serial_align(input logic [SER_W-1:0] w,
                                                      input logic [LEN_W-1:0] len);
    logic [PHASE_W-1:0] ext;
    int                 sh;
    ext = {w, {PAD_W{1'b0}}};
    sh  = 8 * (SER_BYTES - serial_bytes(len));
    return ext << sh;
  endfunction

  // mask of the increment bits lying below a serial word of the given length
  function automatic logic [PHASE_W-1:0] below_serial_mask(input logic [LEN_W-1:0] len);
    logic [PHASE_W-1:0] one;
    int                 pos;
    one = {{(PHASE_W-1){1'b0}}, 1'b1};
    pos = PHASE_W - 8 * serial_bytes(len);
    return (one << pos) - one;
  endfunction

  // modulo 2^PHASE_W sum of three terms; carries beyond the MSB are dropped
  function automatic logic [PHASE_W-1:0] phase_sum3(input logic [PHASE_W-1:0] a,
                                                    input logic [PHASE_W-1:0] b,
                                                    input logic [PHASE_W-1:0] c);
    logic [PHASE_W+1:0] full;
    full = {2'b00, a} + {2'b00, b} + {2'b00, c};
    return full[PHASE_W-1:0];
  endfunction

  // quadrant rotation added into the top address bits
  function automatic logic [ADDR_W-1:0] quad_rotate(input logic [ADDR_W-1:0] addr,
                                                    input logic [QUAD_W-1:0] q);
    return addr + {q, {(ADDR_W-QUAD_W){1'b0}}};
  endfunction

endpackage

// File: rtl/nco_sync.sv
module nco_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nco_freq_sum.sv
module nco_freq_sum
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] center_word,
  input  logic               center_en,
  input  logic [PHASE_W-1:0] offset_word,
  input  logic               offset_en_s,
  input  logic [SER_W-1:0]   serial_word,
  input  logic [LEN_W-1:0]   serial_len,
  input  logic               serial_en,
  output logic [PHASE_W-1:0] inc_o,
  output logic               valid_o
);

  logic [PHASE_W-1:0] sf_aligned;
  logic [PHASE_W-1:0] cf_term, of_term, sf_term;
  logic [PHASE_W-1:0] inc_next;
  logic               all_terms_off;
  logic [PHASE_W-1:0] inc_q;
  logic               valid_q;

  assign sf_aligned    = serial_align(serial_word, serial_len);
  assign cf_term       = center_en   ? center_word : '0;
  assign of_term       = offset_en_s ? offset_word : '0;
  assign sf_term       = serial_en   ? sf_aligned  : '0;
  assign inc_next      = phase_sum3(cf_term, of_term, sf_term);
  assign all_terms_off = !center_en && !offset_en_s && !serial_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q   <= RESET_CENTER;
      valid_q <= 1'b0;
    end else begin
      inc_q   <= inc_next;
      valid_q <= in_valid;
    end
  end

  assign inc_o   = inc_q;
  assign valid_o = valid_q;

  // R2
  all_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    all_terms_off |=> (inc_q == '0));

  // R4
  serial_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((sf_aligned & below_serial_mask(serial_len)) == '0));

  // R6
  inc_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (inc_q == RESET_CENTER && !valid_q));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] inc_i,
  input  logic               valid_i,
  input  logic [QUAD_W-1:0]  quad_s,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               valid_o
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_next;
  logic [ADDR_W-1:0]  acc_top;
  logic [ADDR_W-1:0]  addr_q;
  logic               vacc_q;
  logic               vout_q;

  assign acc_next = phase_sum3(acc_q, inc_i, '0);
  assign acc_top  = acc_q[PHASE_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      vacc_q <= 1'b0;
      addr_q <= '0;
      vout_q <= 1'b0;
    end else begin
      acc_q  <= acc_next;
      vacc_q <= valid_i;
      addr_q <= quad_rotate(acc_top, quad_s);
      vout_q <= vacc_q;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = vout_q;

  // R3
  hold_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i == '0) |=> $stable(acc_q));

  // R5
  quad_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_q[ADDR_W-QUAD_W-1:0] == $past(acc_q[PHASE_W-QUAD_W-1 -: ADDR_W-QUAD_W])));

  // R6
  acc_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (acc_q == '0 && addr_q == '0 && !vout_q));

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] center_word,
  input  logic               center_en,
  input  logic [PHASE_W-1:0] offset_word,
  input  logic               offset_en,
  input  logic [SER_W-1:0]   serial_word,
  input  logic [LEN_W-1:0]   serial_len,
  input  logic               serial_en,
  input  logic [QUAD_W-1:0]  quad_sel,
  output logic [ADDR_W-1:0]  phase_addr,
  output logic               addr_valid
);

  localparam int SYNC_STAGES = 2;

  logic               offset_en_s;
  logic [QUAD_W-1:0]  quad_s;
  logic [PHASE_W-1:0] inc_w;
  logic               inc_valid;

  nco_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ofs (
    .clk (clk), .rst (rst), .d (offset_en), .q (offset_en_s)
  );

  nco_sync #(.W(QUAD_W), .STAGES(SYNC_STAGES)) u_sync_quad (
    .clk (clk), .rst (rst), .d (quad_sel), .q (quad_s)
  );

  nco_freq_sum u_sum (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .center_word (center_word),
    .center_en   (center_en),
    .offset_word (offset_word),
    .offset_en_s (offset_en_s),
    .serial_word (serial_word),
    .serial_len  (serial_len),
    .serial_en   (serial_en),
    .inc_o       (inc_w),
    .valid_o     (inc_valid)
  );

  nco_phase_acc u_acc (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (inc_w),
    .valid_i (inc_valid),
    .quad_s  (quad_s),
    .addr_o  (phase_addr),
    .valid_o (addr_valid)
  );

  // cycles since reset, saturating, used only by the valid checks
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(in_valid, 3));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_valid, 3)) |-> addr_valid);

  // R7
  quad_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (quad_s == $past(quad_sel, 2)));

endmodule

// File: tb/tb_nco_phase_core.sv
module tb_nco_phase_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [47:0] center_word = '0;
  logic        center_en = 1'b0;
  logic [47:0] offset_word = '0;
  logic        offset_en = 1'b0;
  logic [39:0] serial_word = '0;
  logic [2:0]  serial_len = '0;
  logic        serial_en = 1'b0;
  logic [1:0]  quad_sel = '0;
  logic [23:0] phase_addr;
  logic        addr_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nco_phase_core dut (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .center_word (center_word), .center_en (center_en),
    .offset_word (offset_word), .offset_en (offset_en),
    .serial_word (serial_word), .serial_len (serial_len), .serial_en (serial_en),
    .quad_sel (quad_sel), .phase_addr (phase_addr), .addr_valid (addr_valid)
  );

  typedef struct packed {
    logic        cen;
    logic [47:0] cw;
    logic        oen;
    logic [47:0] ow;
    logic        sen;
    logic [39:0] sw;
    logic [2:0]  sl;
    logic [23:0] step;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 48'h4000_0000_0000, 1'b0, 48'h0, 1'b0, 40'h0, 3'd0, 24'h400000, 4'd3},                       // R3 quarter rate
    '{1'b1, 48'h4000_0000_0000, 1'b1, 48'hC000_0000_0000, 1'b0, 40'h0, 3'd0, 24'h000000, 4'd1},          // R1 cancel
    '{1'b1, 48'h0000_0100_0000, 1'b0, 48'h7777_0000_0000, 1'b0, 40'h0, 3'd0, 24'h000001, 4'd2},          // R2 offset off
    '{1'b0, 48'h1234_0000_0000, 1'b1, 48'h0000_0200_0000, 1'b0, 40'h0, 3'd0, 24'h000002, 4'd2},          // R2 center off
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'hFF_FFFF_FFAB, 3'd0, 24'hAB0000, 4'd4},                         // R4 8 bits
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'hFF_FFFF_BEEF, 3'd1, 24'hBEEF00, 4'd4},                         // R4 16 bits
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'hFF_FF12_3456, 3'd2, 24'h123456, 4'd4},                         // R4 24 bits
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'hEE_1234_5600, 3'd3, 24'h123456, 4'd4},                         // R4 32 bits
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'h12_3456_0000, 3'd4, 24'h123456, 4'd4},                         // R4 40 bits
    '{1'b0, 48'h0, 1'b0, 48'h0, 1'b1, 40'h12_3456_0000, 3'd7, 24'h123456, 4'd4},                         // R4 code 7
    '{1'b1, 48'h0010_0000_0000, 1'b1, 48'h0001_0000_0000, 1'b1, 40'h00_0000_0001, 3'd0, 24'h011100, 4'd1}, // R1 three terms
    '{1'b1, 48'hFFFF_FF00_0000, 1'b1, 48'h0000_0200_0000, 1'b0, 40'h0, 3'd0, 24'h000001, 4'd1},          // R1 carry dropped
    '{1'b1, 48'h0000_0300_0000, 1'b0, 48'h0, 1'b0, 40'hFF_FFFF_FFFF, 3'd4, 24'h000003, 4'd2}             // R2 serial off
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    center_en = 1'b0; offset_en = 1'b0; serial_en = 1'b0;
    quad_sel = 2'd0; in_valid = 1'b0;
    edges(3);
    rst = 1'b0;
  endtask

  initial begin
    logic [23:0] a0, a1, base;
    edges(4);
    // R6 state while held in reset
    check("R6 addr in reset", {24'h0, phase_addr}, 48'h0);
    check("R6 valid in reset", {47'h0, addr_valid}, 48'h0);
    rst = 1'b0;
    edges(1);
    check("R6 first edge", {24'h0, phase_addr}, 48'h0);
    edges(1);
    check("R6 second edge", {24'h0, phase_addr}, 48'h400000);
    edges(1);
    check("R6 third edge", {24'h0, phase_addr}, 48'h400000);

    // table of frequency settings, step between consecutive addresses
    in_valid = 1'b1;
    for (int i = 0; i < NV; i++) begin
      center_en   = VECS[i].cen;  center_word = VECS[i].cw;
      offset_en   = VECS[i].oen;  offset_word = VECS[i].ow;
      serial_en   = VECS[i].sen;  serial_word = VECS[i].sw;
      serial_len  = VECS[i].sl;
      edges(6);
      a0 = phase_addr;
      edges(1);
      a1 = phase_addr;
      check($sformatf("R%0d vector %0d step", VECS[i].req, i), {24'h0, a1 - a0}, {24'h0, VECS[i].step});
    end
    check("R8 valid steady", {47'h0, addr_valid}, 48'h1);

    // R5 quadrant rotation with a frozen accumulator, R7 latency of quad_sel
    do_reset();
    edges(4);
    check("R5 base", {24'h0, phase_addr}, 48'h400000);
    quad_sel = 2'd1;
    edges(2);
    check("R7 quad not yet", {24'h0, phase_addr}, 48'h400000);
    edges(1);
    check("R7 R5 quad 1", {24'h0, phase_addr}, 48'h800000);
    quad_sel = 2'd2;
    edges(3);
    check("R5 quad 2", {24'h0, phase_addr}, 48'hC00000);
    quad_sel = 2'd3;
    edges(3);
    check("R5 quad 3 wraps", {24'h0, phase_addr}, 48'h000000);
    quad_sel = 2'd0;
    edges(3);

    // R7 offset enable latency
    offset_word = 48'h0000_0100_0000;
    base = phase_addr;
    offset_en = 1'b1;
    edges(4);
    check("R7 offset not yet", {24'h0, phase_addr}, {24'h0, base});
    edges(1);
    check("R7 offset at fifth edge", {24'h0, phase_addr}, {24'h0, base + 24'h1});
    offset_en = 1'b0;
    edges(6);

    // R8 single valid pulse
    in_valid = 1'b1;
    edges(1);
    in_valid = 1'b0;
    edges(1);
    check("R8 after two edges", {47'h0, addr_valid}, 48'h0);
    edges(1);
    check("R8 after three edges", {47'h0, addr_valid}, 48'h1);
    edges(1);
    check("R8 after four edges", {47'h0, addr_valid}, 48'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule